// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a watchdog that counts in sixteenths of a second. Software programs a control byte that holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is the multiplier times four raised to the resolution code, counted in ticks. A one-cycle strobe on `tick` marks each sixteenth of a second. Software keeps the system alive by rewriting the control byte or by reading the status byte. Either access reloads the countdown.

When the count runs out, the block sets a sticky timeout flag. The steering bit then picks one of two actions:

- **Steering bit set:** the block pulses a reset request for one cycle. It also clears the control byte and a century bit kept in a day byte.
- **Steering bit clear:** the block pulses an interrupt for one cycle and keeps the control byte.

After an expiry, the counter waits idle until the next write or kick. A multiplier of zero disables the watchdog.

Top module: `wdog_timer`

## Requirements
- R1: The timeout equals multiplier (control bits 6:2) × 4^(control bits 1:0) ticks. Expiry happens on exactly that many `tick` strobes after the last reload. The action pulse appears in the cycle after the final tick.
- R2: Register offsets are as follows. The control byte is at offset 7 and can be read and written. The status byte is at offset 0, with the timeout flag in bit 7. The day byte is at offset 12 and holds the century bit in bit 6. All other bits and offsets read as zero.
- R3: Writing the control byte clears the timeout flag and restarts the countdown with the newly written interval.
- R4: Reading the status byte (sel and rd_en at offset 0) restarts the countdown from the stored control byte. It does not change the flag.
- R5: Every expiry sets the timeout flag (`wd_flag` and status bit 7).
- R6: If control bit 7 is 1 at expiry, `rst_req` is high for exactly one cycle. The control byte then reads 0x00 and the century bit reads 0.
- R7: If control bit 7 is 0 at expiry, `irq` is high for exactly one cycle and the control byte keeps its value.
- R8: Writes to the status byte have no effect.
- R9: A control byte whose multiplier is zero never causes an expiry.
- R10: After an expiry, no further pulse occurs until the next write or kick, however many ticks arrive.
- R11: After reset, all outputs are 0, every register reads 0 and no countdown runs.
- R12: A reload in the same cycle as a tick takes priority, so that tick cannot cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 1/16 s |
| sel | input | 1 | Bus access strobe |
| wr_en | input | 1 | Write qualifier |
| rd_en | input | 1 | Read qualifier |
| addr | input | 4 | Byte offset in the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with its default widths: a 5-bit multiplier and a 2-bit resolution code, which give an 11-bit counter. With those defaults, every resolution code can be exercised, up to the longest timeout of 1984 ticks. Both the smallest interval (a single tick) and multiplier zero are within reach. Because the bench drives the tick strobe directly, it can place a reload in the same cycle as the final tick, and it can count ticks exactly to the expiry edge.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'd0,
  parameter logic [ADDR_W-1:0] WDOG_ADDR = 4'd7,
  parameter logic [ADDR_W-1:0] DAY_ADDR  = 4'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rst_req,
  output logic              irq,
  output logic              wd_flag
);
  localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);
  localparam int STEER_B = RES_W + MULT_W;

  logic [7:0]       wreg;
  logic             century;
  logic             active;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] interval(input logic [7:0] v);
    logic [CNT_W-1:0] m;
    m = CNT_W'(v[STEER_B-1:RES_W]);
    return m << {v[RES_W-1:0], 1'b0};
  endfunction

  wire              wr_wd    = sel & wr_en & (addr == WDOG_ADDR);
  wire              wr_day   = sel & wr_en & (addr == DAY_ADDR);
  wire              kick     = sel & rd_en & (addr == FLAG_ADDR);
  wire              load     = wr_wd | kick;
  wire [CNT_W-1:0]  load_val = wr_wd ? interval(wdata) : interval(wreg);
  wire              expire   = active & tick & (cnt == CNT_W'(1)) & ~load;
  wire              hard     = expire & wreg[STEER_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wreg    <= '0;
      century <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      wd_flag <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= hard;
      irq     <= expire & ~wreg[STEER_B];

      if (load) begin
        cnt    <= load_val;
        active <= (load_val != '0);
      end else if (active && tick) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) active <= 1'b0;
      end

      if (wr_wd)     wreg <= wdata;
      else if (hard) wreg <= '0;

      if (hard)        century <= 1'b0;
      else if (wr_day) century <= wdata[6];

      if (wr_wd)       wd_flag <= 1'b0;
      else if (expire) wd_flag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == FLAG_ADDR)      rdata = {wd_flag, 7'b0};
    else if (addr == WDOG_ADDR) rdata = wreg;
    else if (addr == DAY_ADDR)  rdata = {1'b0, century, 6'b0};
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
  AST_ACTIONS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(irq && rst_req)); // R6
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) (irq || rst_req) |-> wd_flag); // R5
  AST_HARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> (wreg == 8'h00 && !century)); // R6
  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) wr_wd |=> !wd_flag); // R3
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !active |=> !(irq || rst_req)); // R10
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) load |=> !(irq || rst_req)); // R12
endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_req, irq, wd_flag;
  int         total = 0, bad = 0;
  int         n_irq = 0, n_rst = 0;

  always #5 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .irq(irq), .wd_flag(wd_flag)
  );

  always @(negedge clk) begin
    if (irq) n_irq++;
    if (rst_req) n_rst++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; #1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic with_tick);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0; tick = 1'b0; #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); sel = 1'b0; rd_en = 1'b0; #1;
  endtask

  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {8'h04, 12'd1,    1'b0},
    {8'h0D, 12'd12,   1'b0},
    {8'h0A, 12'd32,   1'b0},
    {8'h07, 12'd64,   1'b0},
    {8'h7C, 12'd31,   1'b0},
    {8'h85, 12'd4,    1'b1},
    {8'h7F, 12'd1984, 1'b0}
  };

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int i0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    check("R11 outputs", {rst_req, irq, wd_flag}, 0);
    rd(4'd0, d);  check("R11 status", d, 0);
    rd(4'd7, d);  check("R11 control", d, 0);
    do_tick(5);
    check("R11 idle", n_irq + n_rst, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0]  cv;
      logic [11:0] nt;
      logic        hr;
      {cv, nt, hr} = VEC[v];
      wr(4'd7, cv, 1'b0);
      check("R3 flag cleared", wd_flag, 0);
      i0 = n_irq; r0 = n_rst;
      do_tick(int'(nt) - 1);
      check("R1 no early expiry", n_irq + n_rst - i0 - r0, 0);
      do_tick(1);
      check(hr ? "R6 reset pulse" : "R7 irq pulse", hr ? n_rst - r0 : n_irq - i0, 1);
      check("R1 other action idle", hr ? n_irq - i0 : n_rst - r0, 0);
      check("R5 flag", wd_flag, 1);
      @(negedge clk); #1;
      check("R6 R7 single cycle", {rst_req, irq}, 0);
      rd(4'd7, d);
      check(hr ? "R6 control cleared" : "R7 control kept", d, hr ? 0 : cv);
    end

    wr(4'd12, 8'h40, 1'b0);
    rd(4'd12, d); check("R2 century", d, 8'h40);
    wr(4'd7, 8'h84, 1'b0);
    do_tick(1);
    rd(4'd12, d); check("R6 century cleared", d, 0);
    rd(4'd0, d);  check("R2 R5 status bit7", d, 8'h80);
    rd(4'd3, d);  check("R2 unused offset", d, 0);

    wr(4'd0, 8'h00, 1'b0);
    rd(4'd0, d); check("R8 write ignored (set)", d, 8'h80);
    wr(4'd7, 8'h00, 1'b0);
    wr(4'd0, 8'hFF, 1'b0);
    rd(4'd0, d); check("R8 write ignored (clear)", d, 0);

    i0 = n_irq; r0 = n_rst;
    wr(4'd7, 8'h03, 1'b0);
    do_tick(100);
    check("R9 zero multiplier", n_irq + n_rst - i0 - r0, 0);

    wr(4'd7, 8'h10, 1'b0);
    i0 = n_irq;
    do_tick(3);
    rd(4'd0, d);
    check("R4 kick keeps flag", d, 0);
    do_tick(3);
    check("R4 kick reloads", n_irq - i0, 0);
    do_tick(1);
    check("R4 expiry after kick", n_irq - i0, 1);
    do_tick(20);
    check("R10 idle after expiry", n_irq - i0, 1);

    wr(4'd7, 8'h04, 1'b0);
    i0 = n_irq;
    wr(4'd7, 8'h04, 1'b1);
    check("R12 reload beats tick", n_irq - i0, 0);
    do_tick(1);
    check("R12 later expiry", n_irq - i0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule